// File: doc/BRIEF.md
# Multi-CPU Device Interrupt Router

This block takes up to 64 level-sensitive device interrupt lines and gathers them into a raw request vector. The vector is sampled once per clock. PCI interrupt pins are folded into that vector by a fixed arithmetic rule, and so is the output of a cascaded ISA interrupt controller. Each of four CPUs has its own 64-bit enable mask over the shared vector. A CPU's interrupt output is raised whenever its masked request is nonzero.

Software reaches the masks, the per-CPU masked requests and the raw vector through a 32-bit CSR port. Each 64-bit register is split into two 32-bit halves, and a single shared holding register joins the halves. Writing a low half only loads the holding register. Writing the matching high half commits the full 64-bit value. Reading a low half returns the low word and parks the upper word in the holding register, and the next read of a high half returns that parked word. Read data and the error flag appear on the cycle after the request.

Top module: `irq_router`

## Requirements
- R1: Each raw request bit is the OR of its input lines, sampled on every clock edge. The bit is set while a line is high and cleared once all of its lines are low. The raw vector reads at offset 0x300 (low word) and 0x304 (high word).
- R2: PCI input `pci_int[s*4+p]` (slot s, pin p in 0..3) drives raw bit (s+1)*4+p.
- R3: The ISA cascade input `isa_int` drives raw bit 55.
- R4: `cpu_irq[c]` is high exactly when mask c AND the raw vector is nonzero. It changes on the clock edge that updates either of them.
- R5: The masked request for CPU c reads at offsets 0x280, 0x2C0, 0x680 and 0x6C0 for c = 0..3, and its value is mask c AND raw. Writes to these offsets and to the raw vector leave every mask and every output unchanged.
- R6: Mask c sits at offsets 0x200, 0x240, 0x600 and 0x640 for c = 0..3. Writing the high half (address bit 2 set) commits {wdata, holding register} into the mask.
- R7: Reading a low half returns bits 31:0 and loads bits 63:32 into the holding register. Reading a high half returns the holding register. `csr_rdata` is valid one cycle after the request.
- R8: During synchronous active-low reset, every mask, the holding register and `csr_rdata` clear to zero, and all `cpu_irq` outputs are low.
- R9: An access to any other offset, or to one with address bits 1:0 nonzero, returns 0xFFFFFFFF. It pulses `csr_err` for one cycle, one cycle after the request, and changes neither the masks nor the holding register.
- R10: A low-half write only loads the holding register. The target mask keeps its old value until the high half is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ext_irq | input | 64 | Generic device lines, one per raw bit |
| pci_int | input | NUM_SLOTS*4 | PCI interrupt pins, index slot*4+pin |
| isa_int | input | 1 | Cascaded ISA controller output |
| csr_valid | input | 1 | CSR access request |
| csr_write | input | 1 | 1 = write, 0 = read |
| csr_addr | input | 12 | CSR byte offset |
| csr_wdata | input | 32 | Write data half |
| csr_rdata | output | 32 | Read data, one cycle after request |
| csr_err | output | 1 | Unmapped access pulse |
| cpu_irq | output | NUM_CPUS | Hardware interrupt per CPU |

## Verification
The bench builds the router with its defaults: four CPUs, twelve PCI slots and the ISA input on bit 55. With these values all four mask offsets and all four request offsets are decoded. PCI bits reach from 4 up to 51, so the top slot's pins and the ISA bit are both driven while the remaining bits come from the generic lines. A behavioural model tracks the raw vector, the masks and the holding register every clock. This catches any wrong offset, a half-order mistake, or a holding register disturbed by an unmapped or read-only access.

// File: rtl/irq_router_pkg.sv
// Package: shared constants, decode types and offset helpers for the
// interrupt router. Assumes a fixed 12-bit CSR offset space.
package irq_router_pkg;
    localparam int HALF_W = 32;
    localparam int REG_W  = 2 * HALF_W;
    localparam int ADDR_W = 12;
    localparam logic [ADDR_W-1:0] RAW_OFS = 12'h300;
    localparam logic [ADDR_W-1:0] REQ_GAP = 12'h080;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_MASK = 2'd1,
        SEL_REQ  = 2'd2,
        SEL_RAW  = 2'd3
    } csr_sel_e;

    typedef struct packed {
        csr_sel_e   sel;
        logic [1:0] cpu;
        logic       hi;
    } csr_dec_t;

    // Mask offset of a CPU: pairs at 0x200/0x240 and 0x600/0x640.
    function automatic logic [ADDR_W-1:0] mask_ofs(input int unsigned cpu);
        logic [ADDR_W-1:0] base;
        base = (cpu[1]) ? 12'h600 : 12'h200;
        return base + ((cpu[0]) ? 12'h040 : 12'h000);
    endfunction
endpackage

// File: rtl/irq_raw_collect.sv
// Module: gathers generic, PCI and ISA lines into the raw request vector.
// Assumes (NUM_SLOTS+1)*4 <= REG_W; lines are level sensitive.
module irq_raw_collect
    import irq_router_pkg::*;
#(
    parameter int NUM_SLOTS = 12,
    parameter int ISA_BIT   = 55
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [REG_W-1:0]       ext_irq,
    input  logic [NUM_SLOTS*4-1:0] pci_int,
    input  logic                   isa_int,
    output logic [REG_W-1:0]       raw_q
);
    localparam int PCI_LO = 4;
    localparam int PCI_HI = (NUM_SLOTS + 1) * 4;

    logic [REG_W-1:0] pci_vec;
    logic [REG_W-1:0] isa_vec;

    // Slot s pin p lands on bit (s+1)*4+p, i.e. input index bit-4.
    for (genvar b = 0; b < REG_W; b++) begin : g_pci_map
        if (b >= PCI_LO && b < PCI_HI) begin : g_on
            assign pci_vec[b] = pci_int[b-PCI_LO];
        end else begin : g_off
            assign pci_vec[b] = 1'b0;
        end
        assign isa_vec[b] = (b == ISA_BIT) ? isa_int : 1'b0;
    end

    // Sample the combined level of every request line.
    always_ff @(posedge clk) begin
        if (!rst_n) raw_q <= '0;
        else        raw_q <= ext_irq | pci_vec | isa_vec;
    end
endmodule

// File: rtl/irq_csr_port.sv
// Module: 32-bit CSR port over 64-bit registers with a shared holding
// register; owns the per-CPU masks. Assumes NUM_CPUS <= 4.
module irq_csr_port
    import irq_router_pkg::*;
#(
    parameter int NUM_CPUS = 4
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           csr_valid,
    input  logic                           csr_write,
    input  logic [ADDR_W-1:0]              csr_addr,
    input  logic [HALF_W-1:0]              csr_wdata,
    input  logic [REG_W-1:0]               raw_q,
    output logic [NUM_CPUS-1:0][REG_W-1:0] mask_q,
    output logic [HALF_W-1:0]              csr_rdata,
    output logic                           csr_err
);
    csr_dec_t          dec;
    logic [ADDR_W-1:0] base;
    logic [REG_W-1:0]  rd_val;
    logic [HALF_W-1:0] hold_q;
    logic              hit;
    logic              wr_lo;
    logic              wr_hi;

    assign base = {csr_addr[ADDR_W-1:3], 3'b000};

    // Decode the offset into a register class, CPU and half.
    always_comb begin
        dec.sel = SEL_NONE;
        dec.cpu = 2'd0;
        dec.hi  = csr_addr[2];
        if (csr_addr[1:0] == 2'b00) begin
            if (base == RAW_OFS) dec.sel = SEL_RAW;
            for (int c = 0; c < NUM_CPUS; c++) begin
                if (base == mask_ofs(c)) begin
                    dec.sel = SEL_MASK;
                    dec.cpu = 2'(c);
                end
                if (base == mask_ofs(c) + REQ_GAP) begin
                    dec.sel = SEL_REQ;
                    dec.cpu = 2'(c);
                end
            end
        end
    end

    // Select the full 64-bit value of the addressed register.
    always_comb begin
        case (dec.sel)
            SEL_MASK: rd_val = mask_q[dec.cpu];
            SEL_REQ:  rd_val = mask_q[dec.cpu] & raw_q;
            SEL_RAW:  rd_val = raw_q;
            default:  rd_val = '0;
        endcase
    end

    assign hit   = csr_valid && (dec.sel != SEL_NONE);
    assign wr_lo = hit && csr_write && !dec.hi;
    assign wr_hi = hit && csr_write && dec.hi && (dec.sel == SEL_MASK);

    // Holding register: loaded by low-half writes and low-half reads.
    always_ff @(posedge clk) begin
        if (!rst_n)                     hold_q <= '0;
        else if (wr_lo)                 hold_q <= csr_wdata;
        else if (hit && !csr_write && !dec.hi)
                                        hold_q <= rd_val[REG_W-1:HALF_W];
    end

    // Read data and error pulse, one cycle after the request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            csr_rdata <= '0;
            csr_err   <= 1'b0;
        end else begin
            csr_err <= csr_valid && (dec.sel == SEL_NONE);
            if (csr_valid && dec.sel == SEL_NONE)
                csr_rdata <= '1;
            else if (hit && !csr_write)
                csr_rdata <= dec.hi ? hold_q : rd_val[HALF_W-1:0];
        end
    end

    for (genvar c = 0; c < NUM_CPUS; c++) begin : g_mask
        // Commit a full mask on its high-half write.
        always_ff @(posedge clk) begin
            if (!rst_n)                           mask_q[c] <= '0;
            else if (wr_hi && dec.cpu == 2'(c))   mask_q[c] <= {csr_wdata, hold_q};
        end
    end
endmodule

// File: rtl/irq_cpu_gate.sv
// Module: per-CPU reduction of masked requests into interrupt outputs.
// Assumes mask and raw are registered upstream.
module irq_cpu_gate
    import irq_router_pkg::*;
#(
    parameter int NUM_CPUS = 4
) (
    input  logic [NUM_CPUS-1:0][REG_W-1:0] mask_q,
    input  logic [REG_W-1:0]               raw_q,
    output logic [NUM_CPUS-1:0]            cpu_irq
);
    for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
        assign cpu_irq[c] = |(mask_q[c] & raw_q);
    end
endmodule

// File: rtl/irq_router.sv
// Module: top of the multi-CPU device interrupt router. Assumes
// NUM_CPUS <= 4 and all PCI bits fit below bit 64.
module irq_router
    import irq_router_pkg::*;
#(
    parameter int NUM_CPUS  = 4,
    parameter int NUM_SLOTS = 12,
    parameter int ISA_BIT   = 55
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [63:0]            ext_irq,
    input  logic [NUM_SLOTS*4-1:0] pci_int,
    input  logic                   isa_int,
    input  logic                   csr_valid,
    input  logic                   csr_write,
    input  logic [11:0]            csr_addr,
    input  logic [31:0]            csr_wdata,
    output logic [31:0]            csr_rdata,
    output logic                   csr_err,
    output logic [NUM_CPUS-1:0]    cpu_irq
);
    logic [REG_W-1:0]               raw_q;
    logic [NUM_CPUS-1:0][REG_W-1:0] mask_q;

    irq_raw_collect #(.NUM_SLOTS(NUM_SLOTS), .ISA_BIT(ISA_BIT)) u_raw (
        .clk(clk), .rst_n(rst_n), .ext_irq(ext_irq),
        .pci_int(pci_int), .isa_int(isa_int), .raw_q(raw_q)
    );

    irq_csr_port #(.NUM_CPUS(NUM_CPUS)) u_csr (
        .clk(clk), .rst_n(rst_n), .csr_valid(csr_valid),
        .csr_write(csr_write), .csr_addr(csr_addr), .csr_wdata(csr_wdata),
        .raw_q(raw_q), .mask_q(mask_q), .csr_rdata(csr_rdata),
        .csr_err(csr_err)
    );

    irq_cpu_gate #(.NUM_CPUS(NUM_CPUS)) u_gate (
        .mask_q(mask_q), .raw_q(raw_q), .cpu_irq(cpu_irq)
    );
endmodule

// File: rtl/irq_router_chk.sv
// Module: assertion checker bound to irq_router; observes ports and the
// raw vector and masks that separate submodules drive.
module irq_router_chk #(
    parameter int NUM_CPUS = 4,
    parameter int ISA_BIT  = 55
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [63:0]              ext_irq,
    input logic                     isa_int,
    input logic                     csr_valid,
    input logic                     csr_write,
    input logic [31:0]              csr_rdata,
    input logic                     csr_err,
    input logic [NUM_CPUS-1:0]      cpu_irq,
    input logic [63:0]              raw_q,
    input logic [NUM_CPUS-1:0][63:0] mask_q
);
    AST_RAW_FOLLOWS_LINE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> raw_q[0] == $past(ext_irq[0]));  // R1
    AST_ISA_TO_RAW: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> raw_q[ISA_BIT] == $past(isa_int | ext_irq[ISA_BIT]));  // R3
    AST_MASK_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(csr_valid && csr_write)) |-> $stable(mask_q));  // R6
    AST_ERR_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && csr_err) |-> $past(csr_valid));  // R9
    AST_ERR_ALL_ONES: assert property (@(posedge clk) disable iff (!rst_n)
        csr_err |-> csr_rdata == 32'hFFFF_FFFF);  // R9
    AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> cpu_irq == '0);  // R8

    for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
        AST_IRQ_NEEDS_RAW: assert property (@(posedge clk) disable iff (!rst_n)
            cpu_irq[c] |-> raw_q != '0);  // R4
        AST_IRQ_NEEDS_MASK: assert property (@(posedge clk) disable iff (!rst_n)
            mask_q[c] == '0 |-> !cpu_irq[c]);  // R4
    end
endmodule

bind irq_router irq_router_chk #(.NUM_CPUS(NUM_CPUS), .ISA_BIT(ISA_BIT)) u_chk (
    .clk(clk), .rst_n(rst_n), .ext_irq(ext_irq), .isa_int(isa_int),
    .csr_valid(csr_valid), .csr_write(csr_write), .csr_rdata(csr_rdata),
    .csr_err(csr_err), .cpu_irq(cpu_irq), .raw_q(raw_q), .mask_q(mask_q)
);

// File: tb/irq_router_test.sv
module irq_router_test;
    localparam int NC = 4;
    localparam int NS = 12;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [63:0]     ext_irq = '0;
    logic [NS*4-1:0] pci_int = '0;
    logic            isa_int = 1'b0;
    logic            csr_valid = 1'b0;
    logic            csr_write = 1'b0;
    logic [11:0]     csr_addr = '0;
    logic [31:0]     csr_wdata = '0;
    logic [31:0]     csr_rdata;
    logic            csr_err;
    logic [NC-1:0]   cpu_irq;

    int    n_tests = 0;
    int    n_fail  = 0;
    string cur_tag = "R8";

    // Behavioural reference state.
    logic [63:0] m_raw = '0;
    logic [63:0] m_mask [NC];
    logic [31:0] m_hold = '0;
    logic [31:0] m_rdata = '0;
    logic        m_err = 1'b0;
    logic        m_rdchk = 1'b0;

    irq_router #(.NUM_CPUS(NC), .NUM_SLOTS(NS), .ISA_BIT(55)) uut (
        .clk(clk), .rst_n(rst_n), .ext_irq(ext_irq), .pci_int(pci_int),
        .isa_int(isa_int), .csr_valid(csr_valid), .csr_write(csr_write),
        .csr_addr(csr_addr), .csr_wdata(csr_wdata), .csr_rdata(csr_rdata),
        .csr_err(csr_err), .cpu_irq(cpu_irq)
    );

    always #4 clk = ~clk;

    task automatic check(input bit ok, input string tag, input logic [63:0] act,
                         input logic [63:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // kind: 0 unmapped, 1 mask, 2 request, 3 raw
    function automatic void decode(input logic [11:0] a, output int kind, output int cpu);
        kind = 0; cpu = 0;
        if (a[1:0] == 2'b00) begin
            case ({a[11:3], 3'b000})
                12'h200: begin kind = 1; cpu = 0; end
                12'h240: begin kind = 1; cpu = 1; end
                12'h600: begin kind = 1; cpu = 2; end
                12'h640: begin kind = 1; cpu = 3; end
                12'h280: begin kind = 2; cpu = 0; end
                12'h2C0: begin kind = 2; cpu = 1; end
                12'h680: begin kind = 2; cpu = 2; end
                12'h6C0: begin kind = 2; cpu = 3; end
                12'h300: kind = 3;
                default: kind = 0;
            endcase
        end
    endfunction

    // Reference model step on each rising edge.
    always @(posedge clk) begin
        int kind, cpu;
        logic [63:0] v, nraw;
        nraw = ext_irq;
        for (int s = 0; s < NS; s++)
            for (int p = 0; p < 4; p++)
                if (pci_int[s*4+p]) nraw[(s+1)*4+p] = 1'b1;
        if (isa_int) nraw[55] = 1'b1;
        if (!rst_n) begin
            m_raw = '0; m_hold = '0; m_rdata = '0; m_err = 0; m_rdchk = 0;
            for (int c = 0; c < NC; c++) m_mask[c] = '0;
        end else begin
            m_err = 0; m_rdchk = 0;
            if (csr_valid) begin
                decode(csr_addr, kind, cpu);
                v = (kind == 1) ? m_mask[cpu] :
                    (kind == 2) ? (m_mask[cpu] & m_raw) : m_raw;
                if (kind == 0) begin
                    m_err = 1; m_rdata = '1; m_rdchk = 1;
                end else if (csr_write) begin
                    if (!csr_addr[2]) m_hold = csr_wdata;
                    else if (kind == 1) m_mask[cpu] = {csr_wdata, m_hold};
                end else begin
                    m_rdchk = 1;
                    if (csr_addr[2]) m_rdata = m_hold;
                    else begin m_rdata = v[31:0]; m_hold = v[63:32]; end
                end
            end
            m_raw = nraw;
        end
    end

    // Per-clock comparison against the model, away from the rising edge.
    always @(negedge clk) begin
        if (rst_n) begin
            logic [NC-1:0] exp_irq;
            for (int c = 0; c < NC; c++) exp_irq[c] = |(m_mask[c] & m_raw);
            check(cpu_irq == exp_irq, "R4 cpu_irq", 64'(cpu_irq), 64'(exp_irq));
            check(csr_err == m_err, "R9 csr_err", 64'(csr_err), 64'(m_err));
            if (m_rdchk)
                check(csr_rdata == m_rdata, {cur_tag, " csr_rdata"},
                      64'(csr_rdata), 64'(m_rdata));
        end
    end

    task automatic csr_acc(input bit wr, input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        csr_valid = 1'b1; csr_write = wr; csr_addr = a; csr_wdata = d;
        @(negedge clk);
        csr_valid = 1'b0; csr_write = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic report;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        report();
        $finish;
    end

    initial begin
        // R8: reset state
        idle(4);
        check(cpu_irq == '0, "R8 irq", 64'(cpu_irq), 0);
        check(csr_rdata == '0, "R8 rdata", 64'(csr_rdata), 0);
        check(csr_err == 1'b0, "R8 err", 64'(csr_err), 0);
        rst_n = 1'b1;
        idle(2);
        cur_tag = "R8"; csr_acc(0, 12'h200, 0); csr_acc(0, 12'h644, 0);

        // R1: raw vector follows generic lines
        cur_tag = "R1";
        ext_irq = 64'h0123_4000_0000_F00D;
        idle(2);
        csr_acc(0, 12'h300, 0);
        cur_tag = "R7"; csr_acc(0, 12'h304, 0);
        ext_irq = 64'h8000_0000_0000_0001;
        idle(1);
        cur_tag = "R1"; csr_acc(0, 12'h300, 0); csr_acc(0, 12'h304, 0);
        ext_irq = '0;

        // R10: low half alone leaves the mask untouched
        cur_tag = "R10";
        isa_int = 1'b1;
        csr_acc(1, 12'h200, 32'hFFFF_FFFF);
        idle(2);
        check(cpu_irq[0] == 1'b0, "R10 irq0", 64'(cpu_irq[0]), 0);
        csr_acc(0, 12'h200, 0);

        // R6: high half commits {wdata, holding}
        cur_tag = "R6";
        csr_acc(1, 12'h200, 32'h0000_0000);
        csr_acc(1, 12'h204, 32'h0080_0000);
        idle(1);
        check(cpu_irq[0] == 1'b1, "R6 irq0", 64'(cpu_irq[0]), 1);
        csr_acc(0, 12'h200, 0); csr_acc(0, 12'h204, 0);
        csr_acc(1, 12'h640, 32'hDEAD_BEEF);
        csr_acc(1, 12'h644, 32'h1357_9BDF);
        csr_acc(0, 12'h640, 0); csr_acc(0, 12'h644, 0);

        // R3: ISA cascade on bit 55
        cur_tag = "R3";
        isa_int = 1'b0; idle(2);
        check(cpu_irq[0] == 1'b0, "R3 irq0 low", 64'(cpu_irq[0]), 0);
        isa_int = 1'b1; idle(2);
        check(cpu_irq[0] == 1'b1, "R3 irq0 high", 64'(cpu_irq[0]), 1);
        csr_acc(0, 12'h304, 0); csr_acc(0, 12'h300, 0); csr_acc(0, 12'h304, 0);
        isa_int = 1'b0;

        // R2: PCI slot/pin mapping
        cur_tag = "R2";
        csr_acc(1, 12'h240, 32'hFFFF_FFFF);
        csr_acc(1, 12'h244, 32'hFFFF_FFFF);
        for (int s = 0; s < NS; s += 3) begin
            for (int p = 0; p < 4; p++) begin
                pci_int = '0;
                pci_int[s*4+p] = 1'b1;
                idle(1);
                csr_acc(0, 12'h2C0, 0); csr_acc(0, 12'h2C4, 0);
            end
        end
        pci_int = '0; pci_int[(NS-1)*4+3] = 1'b1;
        idle(1);
        csr_acc(0, 12'h2C0, 0); csr_acc(0, 12'h2C4, 0);
        pci_int = '0;

        // R5: request registers are read-only views
        cur_tag = "R5";
        ext_irq = 64'hFF00_FF00_00FF_00FF;
        csr_acc(1, 12'h600, 32'h0F0F_0F0F);
        csr_acc(1, 12'h604, 32'hF0F0_F0F0);
        csr_acc(0, 12'h680, 0); csr_acc(0, 12'h684, 0);
        csr_acc(1, 12'h680, 32'hFFFF_FFFF);
        csr_acc(1, 12'h684, 32'hFFFF_FFFF);
        csr_acc(1, 12'h304, 32'h0000_0000);
        csr_acc(0, 12'h600, 0); csr_acc(0, 12'h604, 0);
        csr_acc(0, 12'h280, 0); csr_acc(0, 12'h6C0, 0); csr_acc(0, 12'h6C4, 0);

        // R7: high read returns word parked by previous low read
        cur_tag = "R7";
        csr_acc(0, 12'h640, 0);
        csr_acc(0, 12'h304, 0);
        csr_acc(0, 12'h244, 0);

        // R9: unmapped offsets
        cur_tag = "R9";
        csr_acc(0, 12'h200, 0);
        csr_acc(0, 12'h100, 0);
        csr_acc(1, 12'h201, 32'h1234_5678);
        csr_acc(1, 12'h7F8, 32'hAAAA_AAAA);
        csr_acc(1, 12'h7FC, 32'h5555_5555);
        csr_acc(0, 12'h30C, 0);
        csr_acc(0, 12'h204, 0);
        csr_acc(0, 12'h200, 0); csr_acc(0, 12'h204, 0);

        // R4: outputs fall when requests drop
        cur_tag = "R4";
        ext_irq = '0; isa_int = 1'b0; pci_int = '0;
        idle(2);
        check(cpu_irq == '0, "R4 all low", 64'(cpu_irq), 0);
        ext_irq[8] = 1'b1; idle(2);
        csr_acc(1, 12'h240, 32'h0000_0100);
        csr_acc(1, 12'h244, 32'h0);
        idle(2);
        check(cpu_irq[1] == 1'b1, "R4 irq1", 64'(cpu_irq[1]), 1);
        ext_irq = '0; idle(2);

        report();
        $finish;
    end
endmodule